// File: doc/BRIEF.md
# Multi-Mode Reload Timer with Edge Capture

A 16-bit down-counting timer with a writable reload register. Its count pulses come from one of two sources. The first is an internal divide-by-16 prescaler, fed by a main or a slow tick enable. The second is a synchronized external pin. Whenever the count must pass below zero, the block reloads it from the reload register and raises an underflow request. The division ratio is therefore 1/(n+1) for a reload value n.

Two measurement modes use the pin to time intervals. A qualifying pin edge stores the current count in a capture register and restarts the count from the reload value. Both modes raise an edge request. In period mode only the edge chosen by the edge-select input qualifies. In pulse-width mode both edges qualify. The captured value stays put until the next qualifying edge, so software reads interval lengths as (reload − capture). Both requests stay set until software clears them with a write-one strobe.

Top module: `reload_capture_timer`

## Requirements
- R1: After reset, count, capture and the reload register are 0, and both request flags are 0.
- R2: While `run` is 0, a `latch_wr` loads `latch_wdata` into both the reload register and the count. With no write, the count holds its value.
- R3: While `run` is 1, a `latch_wr` changes only the reload register. The count keeps counting, and the new value is used at the next reload.
- R4: In timer mode (`mode`=00), the count drops by one for every 16 ticks of the selected source. That source is `main_tick` when `slow_sel`=0 and `sub_tick` when `slow_sel`=1.
- R5: A count pulse that arrives when the count is 0 reloads the count from the reload register and sets `uf_irq`. A reload value n therefore gives one underflow every n+1 count pulses.
- R6: In event mode (`mode`=10), the count pulse is one selected edge of the synchronized pin: rising for `edge_sel`=0, falling for `edge_sel`=1. The prescaler has no effect in this mode, and `edge_irq` is not set.
- R7: In period mode (`mode`=01), a selected pin edge captures the count from just before the reload, reloads the count from the reload register and sets `edge_irq`. The opposite edge has no effect. The result appears at the third rising clock edge after the pin changes.
- R8: In pulse-width mode (`mode`=11), both rising and falling pin edges capture, reload and set `edge_irq`, whatever the value of `edge_sel`.
- R9: The capture register changes only on a qualifying measurement edge.
- R10: `uf_clr` clears `uf_irq` and `edge_clr` clears `edge_irq`. When a set and a clear fall in the same cycle, the flag ends up set.
- R11: When a measurement edge and a prescaler count pulse fall in the same cycle, the edge wins. The count becomes the reload value and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counting enable |
| slow_sel | input | 1 | 1 selects `sub_tick` as the prescaler source |
| main_tick | input | 1 | Main-clock tick enable |
| sub_tick | input | 1 | Slow-clock tick enable |
| ext_pin | input | 1 | Asynchronous external count/capture pin |
| mode | input | 2 | 00 timer, 01 period, 10 event, 11 pulse-width |
| edge_sel | input | 1 | 0 rising, 1 falling |
| latch_wr | input | 1 | Reload register write strobe |
| latch_wdata | input | 16 | Reload register write data |
| uf_clr | input | 1 | Write-one clear of `uf_irq` |
| edge_clr | input | 1 | Write-one clear of `edge_irq` |
| uf_irq | output | 1 | Underflow request flag |
| edge_irq | output | 1 | Measurement edge request flag |
| count | output | 16 | Live count value |
| capture | output | 16 | Count captured at the last measurement edge |

## Verification
A pin change made between clock edges passes two synchronizer flops and a history flop. It therefore acts on count, capture and `edge_irq` at the third rising edge. The bench drives the pin on a falling edge, steps exactly three rising edges, and samples on the falling edge that follows. With the prescaler running from `main_tick`, count pulses land on every sixteenth rising edge after `run` goes high. The bench counts rising edges from that point and predicts each count and capture with a function of reload value, last reload cycle and current cycle. One edge is placed to collide with a prescaler pulse. Write strobes and clear strobes take effect at the next rising edge and are checked one cycle later.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER  = 2'b00,
    MODE_PERIOD = 2'b01,
    MODE_EVENT  = 2'b10,
    MODE_PULSE  = 2'b11
  } tmr_mode_e;

  function automatic logic is_measure(input tmr_mode_e m);
    return (m == MODE_PERIOD) || (m == MODE_PULSE);
  endfunction
endpackage

// File: rtl/tmr_pin_edge.sv
`timescale 1ns/1ps
module tmr_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;
  logic                   level;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  assign level = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= level;
  end

  assign rise = level & ~hist_q;
  assign fall = ~level & hist_q;
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow_sel,
  input  logic main_tick,
  input  logic sub_tick,
  output logic tick_out
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

  logic             src_tick;
  logic [PRE_W-1:0] pre_q;

  assign src_tick = run & (slow_sel ? sub_tick : main_tick);
  assign tick_out = src_tick & (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (src_tick) pre_q <= (pre_q == LAST) ? '0 : pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/tmr_down_core.sv
`timescale 1ns/1ps
module tmr_down_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             latch_wr,
  input  logic [CNT_W-1:0] latch_wdata,
  input  logic             cnt_pulse,
  input  logic             meas_edge,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic [CNT_W-1:0] latch_q,
  output logic             uf_evt
);
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] cur,
                                                 input logic [CNT_W-1:0] rld);
    return (cur == '0) ? rld : cur - CNT_W'(1);
  endfunction

  assign uf_evt = run & cnt_pulse & ~meas_edge & (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_wr) latch_q <= latch_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      capture <= '0;
    end else if (!run) begin
      if (latch_wr) count <= latch_wdata;
    end else if (meas_edge) begin
      capture <= count;
      count   <= latch_q;
    end else if (cnt_pulse) begin
      count <= step_down(count, latch_q);
    end
  end
endmodule

// File: rtl/tmr_irq_flag.sv
`timescale 1ns/1ps
module tmr_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/reload_capture_timer.sv
`timescale 1ns/1ps
module reload_capture_timer #(
  parameter int CNT_W       = 16,
  parameter int PRE_DIV     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slow_sel,
  input  logic             main_tick,
  input  logic             sub_tick,
  input  logic             ext_pin,
  input  logic [1:0]       mode,
  input  logic             edge_sel,
  input  logic             latch_wr,
  input  logic [CNT_W-1:0] latch_wdata,
  input  logic             uf_clr,
  input  logic             edge_clr,
  output logic             uf_irq,
  output logic             edge_irq,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture
);
  import tmr_pkg::*;

  tmr_mode_e        mode_e;
  logic             pin_rise;
  logic             pin_fall;
  logic             sel_edge;
  logic             pre_tick;
  logic             cnt_pulse;
  logic             meas_edge;
  logic             uf_evt;
  logic [CNT_W-1:0] latch_q;

  assign mode_e = tmr_mode_e'(mode);

  tmr_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk (clk),
    .rst_n (rst_n),
    .pin (ext_pin),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  tmr_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk (clk),
    .rst_n (rst_n),
    .run (run),
    .slow_sel (slow_sel),
    .main_tick (main_tick),
    .sub_tick (sub_tick),
    .tick_out (pre_tick)
  );

  assign sel_edge  = edge_sel ? pin_fall : pin_rise;
  assign cnt_pulse = (mode_e == MODE_EVENT) ? sel_edge : pre_tick;
  assign meas_edge = run & is_measure(mode_e) &
                     ((mode_e == MODE_PULSE) ? (pin_rise | pin_fall) : sel_edge);

  tmr_down_core #(.CNT_W(CNT_W)) u_core (
    .clk (clk),
    .rst_n (rst_n),
    .run (run),
    .latch_wr (latch_wr),
    .latch_wdata (latch_wdata),
    .cnt_pulse (cnt_pulse),
    .meas_edge (meas_edge),
    .count (count),
    .capture (capture),
    .latch_q (latch_q),
    .uf_evt (uf_evt)
  );

  tmr_irq_flag u_uf_flag (
    .clk (clk),
    .rst_n (rst_n),
    .set (uf_evt),
    .clr (uf_clr),
    .q (uf_irq)
  );

  tmr_irq_flag u_edge_flag (
    .clk (clk),
    .rst_n (rst_n),
    .set (meas_edge),
    .clr (edge_clr),
    .q (edge_irq)
  );
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             latch_wr,
  input logic [CNT_W-1:0] latch_wdata,
  input logic             uf_clr,
  input logic             uf_irq,
  input logic             edge_irq,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] capture,
  input logic [CNT_W-1:0] latch_q,
  input logic             cnt_pulse,
  input logic             meas_edge,
  input logic             uf_evt
);
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !latch_wr) |=> $stable(count)); // R2
  AST_STOP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && latch_wr) |=> (count == $past(latch_wdata))); // R2
  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    latch_wr |=> (latch_q == $past(latch_wdata))); // R3
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_pulse && !meas_edge && count != '0) |=> (count == $past(count) - CNT_W'(1))); // R4
  AST_UF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> (count == $past(latch_q) && uf_irq)); // R5
  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    meas_edge |=> (capture == $past(count) && count == $past(latch_q) && edge_irq)); // R7
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_edge |=> $stable(capture)); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_evt && uf_clr) |=> uf_irq); // R10
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!uf_evt && uf_clr) |=> !uf_irq); // R10
endmodule

bind reload_capture_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .run (run),
  .latch_wr (latch_wr),
  .latch_wdata (latch_wdata),
  .uf_clr (uf_clr),
  .uf_irq (uf_irq),
  .edge_irq (edge_irq),
  .count (count),
  .capture (capture),
  .latch_q (latch_q),
  .cnt_pulse (cnt_pulse),
  .meas_edge (meas_edge),
  .uf_evt (uf_evt)
);

// File: tb/test_reload_capture_timer.sv
`timescale 1ns/1ps
module test_reload_capture_timer;
  logic        clk = 1'b0;
  logic        rst_n, run, slow_sel, main_tick, sub_tick, ext_pin, edge_sel;
  logic [1:0]  mode;
  logic        latch_wr, uf_clr, edge_clr;
  logic [15:0] latch_wdata;
  logic        uf_irq, edge_irq;
  logic [15:0] count, capture;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  reload_capture_timer i_reload_capture_timer (
    .clk (clk), .rst_n (rst_n), .run (run), .slow_sel (slow_sel),
    .main_tick (main_tick), .sub_tick (sub_tick), .ext_pin (ext_pin),
    .mode (mode), .edge_sel (edge_sel), .latch_wr (latch_wr),
    .latch_wdata (latch_wdata), .uf_clr (uf_clr), .edge_clr (edge_clr),
    .uf_irq (uf_irq), .edge_irq (edge_irq), .count (count), .capture (capture)
  );

  // count expected at cycle c after a reload to n at cycle r (pulses every 16th edge)
  function automatic int count_at(input int n, input int r, input int c);
    return n - (c / 16 - r / 16);
  endfunction

  // capture for a pin change driven after edge m: value held on edge m+2
  function automatic int cap_at(input int n, input int r, input int m);
    return count_at(n, r, m + 2);
  endfunction

  // event-mode count after e selected edges from reload value n
  function automatic int event_count(input int n, input int e);
    return n - (e % (n + 1));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    cyc += n;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run = 0; slow_sel = 0; main_tick = 0; sub_tick = 0;
    ext_pin = 0; edge_sel = 0; mode = 2'b00; latch_wr = 0; latch_wdata = '0;
    uf_clr = 0; edge_clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
  endtask

  task automatic load(input logic [15:0] v);
    latch_wr = 1; latch_wdata = v;
    step(1);
    latch_wr = 0;
  endtask

  task automatic start();
    run = 1;
    cyc = 0;
  endtask

  task automatic pin_at(input int m, input logic v);
    step(m - cyc);
    ext_pin = v;
    step(3);
  endtask

  initial begin
    void'($urandom(32'd7351));
    do_reset();
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 capture", capture, 0);
    chk("R1 uf_irq", uf_irq, 0);
    chk("R1 edge_irq", edge_irq, 0);

    // timer mode, reload and underflow
    main_tick = 1;
    load(16'd3);
    chk("R2 stopped load", count, 3);
    step(40);
    chk("R2 stopped hold", count, 3);
    start();
    step(32);
    chk("R4 two pulses", count, 1);
    load(16'd7);
    chk("R3 running write keeps count", count, 1);
    step(63 - cyc);
    chk("R5 at zero", count, 0);
    chk("R5 no flag yet", uf_irq, 0);
    uf_clr = 1;
    step(1);
    uf_clr = 0;
    chk("R3 reload uses new latch", count, 7);
    chk("R10 set wins over clear", uf_irq, 1);
    step(80 - cyc);
    chk("R4 after reload", count, 6);
    uf_clr = 1;
    step(1);
    uf_clr = 0;
    chk("R10 clear", uf_irq, 0);
    slow_sel = 1;
    step(64);
    chk("R4 slow source idle", count, 6);
    sub_tick = 1;
    step(16);
    chk("R4 slow source 16 ticks", count, 5);
    run = 0;
    step(20);
    chk("R2 stopped holds", count, 5);

    // event mode, both polarities, random edge trains
    for (int es = 0; es < 2; es++) begin
      for (int t = 0; t < 3; t++) begin
        int n, toggles, e;
        do_reset();
        mode = 2'b10; edge_sel = es[0]; main_tick = 1;
        n = 3 + int'($urandom % 8);
        load(n[15:0]);
        start();
        toggles = int'($urandom % 31);
        e = 0;
        for (int k = 0; k < toggles; k++) begin
          ext_pin = ~ext_pin;
          if ((es == 0 && ext_pin) || (es == 1 && !ext_pin)) e++;
          step(4);
        end
        step(4);
        chk("R6 event count", count, event_count(n, e));
        chk("R6 underflow flag", uf_irq, (e > n) ? 1 : 0);
        chk("R6 no edge flag", edge_irq, 0);
      end
    end

    // period mode
    do_reset();
    mode = 2'b01; edge_sel = 0; main_tick = 1;
    load(16'd1000);
    start();
    pin_at(100, 1'b1);
    chk("R7 capture", capture, cap_at(1000, 0, 100));
    chk("R7 reload", count, 1000);
    chk("R7 edge flag", edge_irq, 1);
    edge_clr = 1;
    step(1);
    edge_clr = 0;
    chk("R10 edge clear", edge_irq, 0);
    pin_at(150, 1'b0);
    chk("R9 capture held", capture, cap_at(1000, 0, 100));
    chk("R7 other edge no flag", edge_irq, 0);
    chk("R7 other edge no reload", count, count_at(1000, 103, 153));
    pin_at(205, 1'b1);
    chk("R11 capture at collision", capture, cap_at(1000, 103, 205));
    chk("R11 edge beats pulse", count, 1000);
    chk("R11 no underflow", uf_irq, 0);
    step(224 - cyc);
    chk("R7 counting resumes", count, count_at(1000, 208, 224));

    // pulse-width mode, random gaps and random edge_sel
    do_reset();
    mode = 2'b11; edge_sel = $urandom % 2; main_tick = 1;
    load(16'd3000);
    start();
    begin
      int r = 0;
      for (int i = 0; i < 8; i++) begin
        int m;
        m = cyc + 10 + int'($urandom % 150);
        pin_at(m, ~ext_pin);
        chk("R8 capture", capture, cap_at(3000, r, m));
        chk("R8 reload", count, 3000);
        chk("R8 edge flag", edge_irq, 1);
        r = m + 3;
        edge_clr = 1;
        step(1);
        edge_clr = 0;
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule